// File: doc/BRIEF.md
# Split Modulo-6 Up/Down Counter

This block counts through six positions, 0 to 5, arranged in a ring. Each clock edge can take one step forward, take one step back, or hold. The ring is not held in one state register. It is split into two cooperating state machines. The lower machine owns positions 0, 1 and 2, and the upper machine owns positions 3, 4 and 5. Each machine also has one idle state of its own. At any moment exactly one machine is active and the other sits idle.

When the active machine steps past the edge of its own range, it drops into its idle state. In the same edge it signals the other machine, which leaves idle and takes up the position next to the boundary. The output count is built from whichever machine is active. It matches a plain single-register modulo-6 up/down counter on every cycle.

The step inputs and the outputs are plain control and status pins. There is no data stream, so the block has no valid/ready handshake and no back-pressure. A step request is acted on at the clock edge where it is sampled. The count and the activity flags come straight from the state registers, so a step shows up on the outputs after that edge.

Top module: `split_ring_counter`

## Requirements
- R1: While `rst` is high at a rising edge, the count becomes 0, `lo_active` becomes 1 and `hi_active` becomes 0.
- R2: With `up_req`=1 and `dn_req`=0 at an edge, the count after that edge is the previous count plus one, and 5 becomes 0.
- R3: With `dn_req`=1 and `up_req`=0 at an edge, the count after that edge is the previous count minus one, and 0 becomes 5.
- R4: With both step inputs low, or both high, the count and both activity flags are unchanged after the edge.
- R5: Exactly one of `lo_active` and `hi_active` is 1 on every cycle. `lo_active`=1 exactly when the count is 0, 1 or 2.
- R6: A forward step from 2 leaves count 3 with only `hi_active` set. A backward step from 3 leaves count 2 with only `lo_active` set.
- R7: A forward step from 5 leaves count 0 with only `lo_active` set. A backward step from 0 leaves count 5 with only `hi_active` set.
- R8: An idle machine stays idle unless the active machine hands control to it at that edge. A step that stays inside the active machine's range leaves the activity flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| up_req | input | 1 | Request a step forward |
| dn_req | input | 1 | Request a step back |
| count | output | 3 | Current position, 0 to 5 |
| lo_active | output | 1 | Lower machine (positions 0 to 2) is active |
| hi_active | output | 1 | Upper machine (positions 3 to 5) is active |

## Verification
The bench drives the counter with several kinds of input:
- Long runs of forward steps circle the ring more than twice. They cross both handoff points in the upward direction, including the wrap from 5 to 0.
- Long runs of backward steps do the same in the downward direction, including the wrap from 0 to 5.
- Back-and-forth steps right at the 2/3 boundary and at the 5/0 boundary hand control to one machine and straight back again. This separates a correct handoff from one that leaves both machines active or neither.
- Both-high, both-low and pseudo-random step patterns check the hold cases and the mixed traffic.
- A reset in mid-run, taken while the upper machine is active, shows that reset pulls control back to the lower machine.

// File: rtl/split_ring_pkg.sv
package split_ring_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_FWD  = 2'd1,
    STEP_BACK = 2'd2
  } step_e;
endpackage

// File: rtl/step_decode.sv
module step_decode
  import split_ring_pkg::*;
(
  input  logic  up_req,
  input  logic  dn_req,
  output step_e step
);
  always_comb begin
    if (up_req && !dn_req)      step = STEP_FWD;
    else if (dn_req && !up_req) step = STEP_BACK;
    else                        step = STEP_HOLD;
  end
endmodule

// File: rtl/ring_half.sv
module ring_half
  import split_ring_pkg::*;
#(
  parameter int SPAN         = 3,
  parameter bit START_ACTIVE = 1'b1,
  localparam int SW          = $clog2(SPAN + 1),
  localparam int PW          = (SPAN > 1) ? $clog2(SPAN) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  step_e         step,
  input  logic          enter_low,
  input  logic          enter_high,
  output logic          active,
  output logic [PW-1:0] pos,
  output logic          exit_high,
  output logic          exit_low
);
  localparam logic [SW-1:0] IDLE_ST = SW'(SPAN);
  localparam logic [SW-1:0] TOP_ST  = SW'(SPAN - 1);

  logic [SW-1:0] st_q, st_d;

  assign active    = (st_q != IDLE_ST);
  assign pos       = PW'(st_q);
  assign exit_high = active && (step == STEP_FWD)  && (st_q == TOP_ST);
  assign exit_low  = active && (step == STEP_BACK) && (st_q == '0);

  always_comb begin
    st_d = st_q;
    if (!active) begin
      if (enter_low)       st_d = '0;
      else if (enter_high) st_d = TOP_ST;
    end else begin
      unique case (step)
        STEP_FWD:  st_d = (st_q == TOP_ST) ? IDLE_ST : st_q + 1'b1;
        STEP_BACK: st_d = (st_q == '0)     ? IDLE_ST : st_q - 1'b1;
        default:   st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= START_ACTIVE ? '0 : IDLE_ST;
    else     st_q <= st_d;
  end

  // R8: idle stays idle without a handoff request
  assert_idle_holds_R8: assert property (@(posedge clk) disable iff (rst)
    (!active && !enter_low && !enter_high) |=> !active);

  // R6/R7: a handoff request always wakes the idle machine
  assert_handoff_wakes_R6: assert property (@(posedge clk) disable iff (rst)
    (!active && (enter_low || enter_high)) |=> active);
endmodule

// File: rtl/split_ring_counter.sv
module split_ring_counter
  import split_ring_pkg::*;
#(
  parameter int SPAN = 3,
  localparam int RING = 2 * SPAN,
  localparam int CW   = $clog2(RING),
  localparam int PW   = (SPAN > 1) ? $clog2(SPAN) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          up_req,
  input  logic          dn_req,
  output logic [CW-1:0] count,
  output logic          lo_active,
  output logic          hi_active
);
  step_e         step;
  logic [1:0]    act, ex_hi, ex_lo;
  logic [PW-1:0] pos [2];

  step_decode u_dec (
    .up_req(up_req),
    .dn_req(dn_req),
    .step  (step)
  );

  for (genvar g = 0; g < 2; g++) begin : g_half
    ring_half #(
      .SPAN        (SPAN),
      .START_ACTIVE(g == 0)
    ) u_half (
      .clk       (clk),
      .rst       (rst),
      .step      (step),
      .enter_low (ex_hi[1-g]),
      .enter_high(ex_lo[1-g]),
      .active    (act[g]),
      .pos       (pos[g]),
      .exit_high (ex_hi[g]),
      .exit_low  (ex_lo[g])
    );
  end

  assign lo_active = act[0];
  assign hi_active = act[1];
  assign count     = act[0] ? CW'(pos[0]) : CW'(pos[1]) + CW'(SPAN);

  assert_one_active_R5: assert property (@(posedge clk) disable iff (rst)
    $countones({lo_active, hi_active}) == 1);

  assert_count_fwd_R2: assert property (@(posedge clk) disable iff (rst)
    (up_req && !dn_req) |=>
      count == (($past(count) == CW'(RING - 1)) ? '0 : $past(count) + 1'b1));

  assert_count_back_R3: assert property (@(posedge clk) disable iff (rst)
    (dn_req && !up_req) |=>
      count == (($past(count) == '0) ? CW'(RING - 1) : $past(count) - 1'b1));

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (up_req == dn_req) |=> ($stable(count) && $stable(lo_active)));

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (count == '0 && lo_active && !hi_active));
endmodule

// File: tb/test_split_ring_counter.sv
`timescale 1ns/1ps
module test_split_ring_counter;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       up_req = 1'b0;
  logic       dn_req = 1'b0;
  logic [2:0] count;
  logic       lo_active, hi_active;

  int    compared = 0;
  int    mismatched = 0;
  int    cycles = 0;
  int    ref_cnt = 0;
  string tag = "R1";
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  split_ring_counter i_split_ring_counter (
    .clk(clk), .rst(rst), .up_req(up_req), .dn_req(dn_req),
    .count(count), .lo_active(lo_active), .hi_active(hi_active)
  );

  // behavioural reference: plain integer ring position
  always @(posedge clk) begin
    cycles = cycles + 1;
    if (rst) begin
      ref_cnt = 0; tag = "R1";
    end else if (up_req && !dn_req) begin
      tag = (ref_cnt == 5) ? "R7" : (ref_cnt == 2) ? "R6" : "R2";
      ref_cnt = (ref_cnt + 1) % 6;
    end else if (dn_req && !up_req) begin
      tag = (ref_cnt == 0) ? "R7" : (ref_cnt == 3) ? "R6" : "R3";
      ref_cnt = (ref_cnt + 5) % 6;
    end else begin
      tag = "R4";
    end
  end

  task automatic compare();
    compared++;
    if (count !== 3'(ref_cnt)) begin
      mismatched++;
      $display("FAIL %s count actual=%0d expected=%0d", tag, count, ref_cnt);
    end
    compared++;
    if (lo_active !== (ref_cnt < 3) || hi_active !== (ref_cnt >= 3)) begin
      mismatched++;
      $display("FAIL R5/R8 (%s) flags lo/hi actual=%b%b expected=%b%b",
               tag, lo_active, hi_active, ref_cnt < 3, ref_cnt >= 3);
    end
  endtask

  task automatic step(input logic u, input logic d);
    @(negedge clk);
    compare();
    up_req = u; dn_req = d;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    compare();                                        // R1 reset state
    rst = 1'b0;
    for (int i = 0; i < 14; i++) step(1'b1, 1'b0);    // R2, R6, R7 upward
    for (int i = 0; i < 14; i++) step(1'b0, 1'b1);    // R3, R6, R7 downward
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1);     // R4 both high
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0);     // R4 both low
    step(1'b1, 1'b0); step(1'b1, 1'b0);               // to 2 (from 0)
    for (int i = 0; i < 6; i++) step(i[0] ? 1'b0 : 1'b1, i[0] ? 1'b1 : 1'b0); // R6 bounce
    step(1'b0, 1'b1); step(1'b0, 1'b1);               // to 0
    for (int i = 0; i < 6; i++) step(i[0] ? 1'b1 : 1'b0, i[0] ? 1'b0 : 1'b1); // R7 bounce
    for (int i = 0; i < 300; i++) begin               // mixed traffic, R8
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0], lfsr[3]);
    end
    step(1'b1, 1'b0); step(1'b1, 1'b0); step(1'b1, 1'b0); step(1'b1, 1'b0);
    @(negedge clk); compare();
    rst = 1'b1;                                       // R1 mid-run reset
    step(1'b1, 1'b0);
    rst = 1'b0;
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    finish_run();
  end

  initial begin
    wait (cycles > 5000);
    mismatched++;
    $display("FAIL watchdog actual=%0d cycles expected<5000", cycles);
    finish_run();
  end
endmodule